// File: doc/BRIEF.md
# Path Status Byte Generator

This block assembles the outgoing path status byte of one SONET/SDH path once per frame, and produces a flag that tells the downstream framer to invert the outgoing B3 parity byte. The upper nibble of the byte reports far-end block errors (REI-P), taken from the per-frame B3 error count supplied by the receive side. Bits 3:1 carry the remote defect indication (RDI-P). This field comes either from a software value or from the receive-side alarms, and each alarm can be masked on its own. Bit 0 is always zero.

The RDI field has two encodings. Single-bit mode reports any defect as one bit. Enhanced mode picks a 3-bit code by defect class. For test, G1[7:4] and B3 can be corrupted. The corruption is either continuous, or gated so that it covers exactly one frame for each pulse on an external error-insert input.

All inputs are sampled in the clock cycle where the frame strobe is high. Both outputs are registered at that edge and hold their values until the next strobe.

Top module: `path_status_gen`

## Requirements
- R1: Reset sets `g1_o` to 0x00 and `b3_inv_o` to 0. Both outputs change only at the clock edge where `frm_i` is high, and they hold their values between strobes.
- R2: With `rdi_sw_en_i`=1, G1[3:1] equals `rdi_sw_val_i`, whatever the alarms and the mode.
- R3: Enhanced mode (`rdi_enh_i`=1, software off) encodes G1[3:1] by priority. An active AIS or LOP gives 101. Otherwise an active TIM or UNEQ gives 110. Otherwise an active PLM gives 010. With no active alarm the code is 001.
- R4: Single-bit mode (`rdi_enh_i`=0, software off) gives G1[3:1]=100 when any alarm is active and 000 when none is.
- R5: An alarm counts as active only when its inhibit bit is 0. The bit positions of `alarm_i` and `alarm_inh_i` are 0=AIS, 1=LOP, 2=TIM, 3=UNEQ, 4=PLM.
- R6: G1[7:4] equals `b3_errcnt_i` when that count is 0 to 8. Any count above 8 is sent as 0.
- R7: With `rei_inh_i`=1, G1[7:4] is 0 before any corruption is applied.
- R8: With `g1_err_ins_i`=1 and `pulse_mode_i`=0, G1[7:4] is sent inverted in every frame.
- R9: With `b3_err_ins_i`=1 and `pulse_mode_i`=0, `b3_inv_o` is 1 for every frame. When the bit is 0, `b3_inv_o` is 0.
- R10: With `pulse_mode_i`=1, the enabled corruptions (B3 and/or G1) apply only to the frame registered at the first strobe that follows a pulse on `err_pulse_i`. A pulse in the same cycle as a strobe counts for that strobe. Several pulses between two strobes corrupt only one frame.
- R11: G1[0] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_i | input | 1 | Frame strobe, one cycle per frame |
| alarm_i | input | 5 | Receive alarms: 0=AIS, 1=LOP, 2=TIM, 3=UNEQ, 4=PLM |
| alarm_inh_i | input | 5 | Per-alarm RDI inhibit, same bit order |
| b3_errcnt_i | input | CNT_W | Far-end B3 block error count for the frame |
| rdi_sw_en_i | input | 1 | Select the software RDI value |
| rdi_sw_val_i | input | 3 | Software RDI value for G1[3:1] |
| rdi_enh_i | input | 1 | 1 selects enhanced 3-bit RDI, 0 selects single-bit RDI |
| rei_inh_i | input | 1 | Suppress REI-P (nibble forced to 0) |
| b3_err_ins_i | input | 1 | Enable B3 inversion |
| g1_err_ins_i | input | 1 | Enable G1[7:4] inversion |
| pulse_mode_i | input | 1 | Gate the enabled corruptions by error-insert pulses |
| err_pulse_i | input | 1 | External error-insert pulse |
| g1_o | output | 8 | Outgoing path status byte |
| b3_inv_o | output | 1 | Invert the outgoing B3 byte for this frame |

## Verification
The bench builds the block with its defaults: a 4-bit error count and a REI limit of 8. This makes counts 9 to 15 legal inputs, so the rule that turns an out-of-range count into 0 can be driven at the ports next to the in-range boundary values 0 and 8. The 5-bit alarm and inhibit vectors let every priority tie in enhanced mode be set up, and each inhibit can be tested against its own alarm. Pulse timing is driven three ways: between strobes, coincident with a strobe, and as repeated pulses. This covers the one-frame-per-pulse rule.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int ALM_N   = 5;
  localparam int IDX_AIS = 0;
  localparam int IDX_LOP = 1;
  localparam int IDX_TIM = 2;
  localparam int IDX_UNQ = 3;
  localparam int IDX_PLM = 4;

  typedef enum logic [2:0] {
    ERDI_NONE = 3'b001,
    ERDI_PAY  = 3'b010,
    ERDI_SRV  = 3'b101,
    ERDI_CON  = 3'b110
  } erdi_code_t;

  localparam logic [2:0] RDI1_SET = 3'b100;
  localparam logic [2:0] RDI1_CLR = 3'b000;
endpackage

// File: rtl/psg_rdi_sel.sv
module psg_rdi_sel
  import psg_pkg::*;
(
  input  logic [ALM_N-1:0] alarm_i,
  input  logic [ALM_N-1:0] inh_i,
  input  logic             enh_i,
  input  logic             sw_en_i,
  input  logic [2:0]       sw_val_i,
  output logic [2:0]       rdi_o
);
  logic [ALM_N-1:0] live;
  logic srv, con, pay, any;
  erdi_code_t ecode;

  // mask every alarm with its own inhibit
  for (genvar g = 0; g < ALM_N; g++) begin : g_mask
    assign live[g] = alarm_i[g] & ~inh_i[g];
  end

  assign srv = live[IDX_AIS] | live[IDX_LOP];
  assign con = live[IDX_TIM] | live[IDX_UNQ];
  assign pay = live[IDX_PLM];
  assign any = |live;

  always_comb begin
    if (srv)      ecode = ERDI_SRV;
    else if (con) ecode = ERDI_CON;
    else if (pay) ecode = ERDI_PAY;
    else          ecode = ERDI_NONE;
  end

  always_comb begin
    if (sw_en_i)    rdi_o = sw_val_i;
    else if (enh_i) rdi_o = ecode;
    else            rdi_o = any ? RDI1_SET : RDI1_CLR;
  end
endmodule

// File: rtl/psg_rei_sel.sv
module psg_rei_sel #(
  parameter int CNT_W   = 4,
  parameter int REI_MAX = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             inh_i,
  output logic [3:0]       rei_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(REI_MAX);

  always_comb begin
    if (inh_i || (cnt_i > LIMIT)) rei_o = 4'h0;
    else                          rei_o = cnt_i[3:0];
  end
endmodule

// File: rtl/psg_err_gate.sv
module psg_err_gate (
  input  logic clk,
  input  logic rst,
  input  logic frm_i,
  input  logic pulse_i,
  input  logic pulse_mode_i,
  input  logic b3_ins_i,
  input  logic g1_ins_i,
  output logic b3_hit_o,
  output logic g1_hit_o
);
  logic pend_q;
  logic pend_now;
  logic gate;

  // a pulse in the strobe cycle counts for that strobe
  assign pend_now = pend_q | pulse_i;
  assign gate     = pulse_mode_i ? pend_now : 1'b1;
  assign b3_hit_o = b3_ins_i & gate;
  assign g1_hit_o = g1_ins_i & gate;

  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (frm_i) pend_q <= 1'b0;
    else if (pulse_i) pend_q <= 1'b1;
  end
endmodule

// File: rtl/path_status_gen.sv
module path_status_gen
  import psg_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int REI_MAX = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_i,
  input  logic [4:0]       alarm_i,
  input  logic [4:0]       alarm_inh_i,
  input  logic [CNT_W-1:0] b3_errcnt_i,
  input  logic             rdi_sw_en_i,
  input  logic [2:0]       rdi_sw_val_i,
  input  logic             rdi_enh_i,
  input  logic             rei_inh_i,
  input  logic             b3_err_ins_i,
  input  logic             g1_err_ins_i,
  input  logic             pulse_mode_i,
  input  logic             err_pulse_i,
  output logic [7:0]       g1_o,
  output logic             b3_inv_o
);
  logic [2:0] rdi;
  logic [3:0] rei;
  logic       b3_hit, g1_hit;
  logic [7:0] g1_next;

  psg_rdi_sel u_rdi (
    .alarm_i (alarm_i),
    .inh_i   (alarm_inh_i),
    .enh_i   (rdi_enh_i),
    .sw_en_i (rdi_sw_en_i),
    .sw_val_i(rdi_sw_val_i),
    .rdi_o   (rdi)
  );

  psg_rei_sel #(.CNT_W(CNT_W), .REI_MAX(REI_MAX)) u_rei (
    .cnt_i(b3_errcnt_i),
    .inh_i(rei_inh_i),
    .rei_o(rei)
  );

  psg_err_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .frm_i       (frm_i),
    .pulse_i     (err_pulse_i),
    .pulse_mode_i(pulse_mode_i),
    .b3_ins_i    (b3_err_ins_i),
    .g1_ins_i    (g1_err_ins_i),
    .b3_hit_o    (b3_hit),
    .g1_hit_o    (g1_hit)
  );

  assign g1_next = {rei ^ {4{g1_hit}}, rdi, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      g1_o     <= 8'h00;
      b3_inv_o <= 1'b0;
    end else if (frm_i) begin
      g1_o     <= g1_next;
      b3_inv_o <= b3_hit;
    end
  end
endmodule

// File: rtl/path_status_gen_chk.sv
module path_status_gen_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_i,
  input logic             rdi_sw_en_i,
  input logic [2:0]       rdi_sw_val_i,
  input logic             rdi_enh_i,
  input logic             rei_inh_i,
  input logic             b3_err_ins_i,
  input logic             g1_err_ins_i,
  input logic [CNT_W-1:0] b3_errcnt_i,
  input logic [7:0]       g1_o,
  input logic             b3_inv_o
);
  p_bit0_zero_r11: assert property (@(posedge clk) disable iff (rst)
    g1_o[0] == 1'b0);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(frm_i) && !$past(rst)) |-> ($stable(g1_o) && $stable(b3_inv_o)));

  p_sw_rdi_r2: assert property (@(posedge clk) disable iff (rst)
    (frm_i && rdi_sw_en_i) |=> (g1_o[3:1] == $past(rdi_sw_val_i)));

  p_single_r4: assert property (@(posedge clk) disable iff (rst)
    (frm_i && !rdi_sw_en_i && !rdi_enh_i) |=> (g1_o[2:1] == 2'b00));

  p_rei_inh_r7: assert property (@(posedge clk) disable iff (rst)
    (frm_i && rei_inh_i && !g1_err_ins_i) |=> (g1_o[7:4] == 4'h0));

  p_rei_range_r6: assert property (@(posedge clk) disable iff (rst)
    (frm_i && !g1_err_ins_i) |=> (g1_o[7:4] <= 4'd8));

  p_b3_off_r9: assert property (@(posedge clk) disable iff (rst)
    (frm_i && !b3_err_ins_i) |=> !b3_inv_o);
endmodule

bind path_status_gen path_status_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frm_i       (frm_i),
  .rdi_sw_en_i (rdi_sw_en_i),
  .rdi_sw_val_i(rdi_sw_val_i),
  .rdi_enh_i   (rdi_enh_i),
  .rei_inh_i   (rei_inh_i),
  .b3_err_ins_i(b3_err_ins_i),
  .g1_err_ins_i(g1_err_ins_i),
  .b3_errcnt_i (b3_errcnt_i),
  .g1_o        (g1_o),
  .b3_inv_o    (b3_inv_o)
);

// File: tb/path_status_gen_test.sv
module path_status_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm = 1'b0;
  logic [4:0] alm = '0, inh = '0;
  logic [3:0] cnt = '0;
  logic       sw_en = 0, enh = 0, rei_inh = 0, b3_ins = 0, g1_ins = 0, pmode = 0, pulse = 0;
  logic [2:0] sw_val = '0;
  logic [7:0] g1;
  logic       b3inv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  path_status_gen uut (
    .clk(clk), .rst(rst), .frm_i(frm), .alarm_i(alm), .alarm_inh_i(inh),
    .b3_errcnt_i(cnt), .rdi_sw_en_i(sw_en), .rdi_sw_val_i(sw_val),
    .rdi_enh_i(enh), .rei_inh_i(rei_inh), .b3_err_ins_i(b3_ins),
    .g1_err_ins_i(g1_ins), .pulse_mode_i(pmode), .err_pulse_i(pulse),
    .g1_o(g1), .b3_inv_o(b3inv)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model built from the requirements; corruption flag supplied by caller
  function automatic logic [7:0] model(logic corrupt);
    logic [4:0] a;
    logic [2:0] r;
    logic [3:0] e;
    a = alm & ~inh;
    if (sw_en) r = sw_val;
    else if (enh) begin
      if (a[0] | a[1])      r = 3'b101;
      else if (a[2] | a[3]) r = 3'b110;
      else if (a[4])        r = 3'b010;
      else                  r = 3'b001;
    end else r = (a != 0) ? 3'b100 : 3'b000;
    e = (rei_inh || cnt > 8) ? 4'h0 : cnt;
    if (corrupt) e = ~e;
    return {e, r, 1'b0};
  endfunction

  // one strobe; outputs sampled at the following negedge
  task automatic frame();
    @(negedge clk) frm = 1;
    @(negedge clk) frm = 0;
  endtask

  task automatic t_reset();
    check("R1 reset g1", g1, 8'h00);
    check("R1 reset b3", {7'd0, b3inv}, 8'h00);
  endtask

  task automatic t_sw();
    sw_en = 1; sw_val = 3'b011; alm = 5'b11111; enh = 1;
    frame(); check("R2 sw enh", g1, model(0));
    enh = 0; sw_val = 3'b110;
    frame(); check("R2 sw single", g1, model(0));
    sw_en = 0; alm = 0;
  endtask

  task automatic t_enh();
    enh = 1;
    alm = 5'b00000; frame(); check("R3 none", g1, model(0));
    alm = 5'b10100; frame(); check("R3 tim over plm", g1, model(0));
    alm = 5'b11010; frame(); check("R3 lop over all", g1, model(0));
    alm = 5'b10000; frame(); check("R3 plm", g1, {4'h0, 3'b010, 1'b0});
    alm = 5'b00001; frame(); check("R3 ais", g1, {4'h0, 3'b101, 1'b0});
    alm = 0;
  endtask

  task automatic t_single();
    enh = 0;
    alm = 5'b01000; frame(); check("R4 set", g1, {4'h0, 3'b100, 1'b0});
    alm = 5'b00000; frame(); check("R4 clear", g1, 8'h00);
  endtask

  task automatic t_inhibit();
    enh = 1; alm = 5'b10011; inh = 5'b00011;
    frame(); check("R5 server masked", g1, {4'h0, 3'b010, 1'b0});
    inh = 5'b10011; frame(); check("R5 all masked", g1, {4'h0, 3'b001, 1'b0});
    enh = 0; frame(); check("R5 single masked", g1, 8'h00);
    alm = 0; inh = 0;
  endtask

  task automatic t_rei();
    cnt = 4'd8; frame(); check("R6 count 8", g1, model(0));
    cnt = 4'd0; frame(); check("R6 count 0", g1, model(0));
    cnt = 4'd9; frame(); check("R6 count 9", g1, 8'h00);
    cnt = 4'd15; frame(); check("R6 count 15", g1, 8'h00);
    cnt = 4'd5; frame(); check("R6 count 5", g1, 8'h50);
  endtask

  task automatic t_rei_inh();
    rei_inh = 1; cnt = 4'd6; frame(); check("R7 inhibit", g1, 8'h00);
    rei_inh = 0;
  endtask

  task automatic t_g1err();
    g1_ins = 1; cnt = 4'd3;
    frame(); check("R8 invert 1", g1, model(1));
    frame(); check("R8 invert 2", g1, 8'hC0);
    g1_ins = 0; frame(); check("R8 cleared", g1, 8'h30);
  endtask

  task automatic t_b3();
    b3_ins = 1;
    frame(); check("R9 b3 on", {7'd0, b3inv}, 8'h01);
    frame(); check("R9 b3 on again", {7'd0, b3inv}, 8'h01);
    b3_ins = 0; frame(); check("R9 b3 off", {7'd0, b3inv}, 8'h00);
  endtask

  task automatic t_pulse();
    pmode = 1; b3_ins = 1; g1_ins = 1; cnt = 4'd2;
    frame(); check("R10 no pulse g1", g1, model(0));
    check("R10 no pulse b3", {7'd0, b3inv}, 8'h00);
    @(negedge clk) pulse = 1; @(negedge clk) pulse = 0;
    @(negedge clk) pulse = 1; @(negedge clk) pulse = 0;
    repeat (3) @(negedge clk);
    frame(); check("R10 pulsed g1", g1, model(1));
    check("R10 pulsed b3", {7'd0, b3inv}, 8'h01);
    frame(); check("R10 consumed g1", g1, model(0));
    check("R10 consumed b3", {7'd0, b3inv}, 8'h00);
    @(negedge clk) begin frm = 1; pulse = 1; end
    @(negedge clk) begin frm = 0; pulse = 0; end
    check("R10 coincident g1", g1, model(1));
    frame(); check("R10 after coincident", g1, model(0));
    pmode = 0; b3_ins = 0; g1_ins = 0;
  endtask

  task automatic t_hold();
    enh = 1; alm = 5'b00100; cnt = 4'd7;
    frame();
    alm = 5'b00001; cnt = 4'd1; b3_ins = 1; g1_ins = 1;
    repeat (5) @(negedge clk);
    check("R1 hold g1", g1, {4'h7, 3'b110, 1'b0});
    check("R1 hold b3", {7'd0, b3inv}, 8'h00);
    check("R11 bit0", {7'd0, g1[0]}, 8'h00);
    b3_ins = 0; g1_ins = 0; alm = 0; cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sw();
    t_enh();
    t_single();
    t_inhibit();
    t_rei();
    t_rei_inh();
    t_g1err();
    t_b3();
    t_pulse();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule